// File: doc/BRIEF.md
# Eight-Bit Register-Zero Accumulator CPU Core

This block is a small single-issue processor core. Each instruction is one byte. It is fetched from a private program memory and retired in the same clock cycle. The core holds eight 8-bit registers and an instruction pointer. Register zero plays three parts. It is the hidden second operand of every two-operand operation, it is the value that conditional branches test, and it is the data register for every memory transfer. The other operand, or the branch target, or the memory address, comes from the register named in the low three bits of the instruction.

Program and data memories are separate address spaces held inside the core. A side write port fills either memory, but only while the core is halted. Combinational peek ports expose any register, any program word and any data word, so a test harness can set up and inspect a run without touching internals. A halt input freezes execution at the current instruction.

Top module: `acc8_core`

## Requirements
- R1: A synchronous reset sets the instruction pointer and all eight registers to zero. It leaves both memories unchanged.
- R2: The instruction byte splits into an opcode in bits [7:3] and an argument in bits [2:0]. Register n is the register the argument names. For and=0, or=1, xor=3, add=4, sub=5 (Rn minus R0) and mul=7 (low 8 bits of the product), the result of Rn combined with R0 is written to Rn.
- R3: not=2 and neg=6 (two's complement) replace Rn with the result computed from Rn. mov=9 copies R0 into Rn. mov0=10 copies Rn into R0. imm=11 writes the argument, zero-extended, into R0.
- R4: shl=12 and shr=13 shift R0 left or right, logically, by the argument count, and write the result back to R0.
- R5: div=8 writes the unsigned quotient Rn / R0 into Rn. When R0 is zero the result is 0xFF and R0 is not changed.
- R6: The branches are bnz=16 (R0 != 0), bz=17 (R0 == 0), b=18 (always), blz=19 (R0 negative) and bgz=20 (R0 positive, nonzero). A taken branch loads the instruction pointer from Rn.
- R7: ld=24 loads data word [Rn] into R0. st=25 writes R0 to data word [Rn]. cl=26 writes zero to data word [Rn].
- R8: swap=27 exchanges R0 and data word [Rn] within a single cycle.
- R9: ld_p=28 loads program word [Rn] into R0. st_p=29 writes R0 to program word [Rn]. The new word is the one fetched if it is the next instruction.
- R10: Any other opcode changes no register and no memory; it only advances the instruction pointer.
- R11: While halt is high, the instruction pointer holds and the core writes nothing. Side-port writes to the memories happen only while halt is high.
- R12: With halt low, one instruction retires every clock. An instruction that does not branch advances the instruction pointer by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes execution when high |
| load_en | input | 1 | Side-port write strobe (honoured while halted) |
| load_prog | input | 1 | Side-port target: 1 program memory, 0 data memory |
| load_addr | input | AW | Side-port word address |
| load_data | input | 8 | Side-port write data |
| peek_reg | input | 3 | Register index to observe |
| peek_reg_data | output | 8 | Contents of the observed register |
| peek_addr | input | AW | Memory address to observe |
| peek_dmem | output | 8 | Data memory word at peek_addr |
| peek_pmem | output | 8 | Program memory word at peek_addr |
| ip | output | AW | Instruction pointer |

## Verification
Two functions of the core can fall in the same cycle. The first is swap: it reads the data word into R0 and writes the old R0 into that word on the same edge. The bench judges it by finding both the old word in a register and the old R0 in memory after the swap. The second is st_p aimed at the very next instruction address, so a program-memory write and the following fetch meet at one edge. The bench provokes this with a program that patches its own next word. The patched opcode, not the preloaded one, must have executed, which the bench sees in the value of R0.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int WORD_W = 8;
  localparam int OPC_W  = 5;
  localparam int ARG_W  = 3;
  localparam int NREG   = 1 << ARG_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ARG_W-1:0]  arg_t;

  typedef enum logic [OPC_W-1:0] {
    OP_AND  = 5'd0,  OP_OR   = 5'd1,  OP_NOT  = 5'd2,  OP_XOR  = 5'd3,
    OP_ADD  = 5'd4,  OP_SUB  = 5'd5,  OP_NEG  = 5'd6,  OP_MUL  = 5'd7,
    OP_DIV  = 5'd8,  OP_MOV  = 5'd9,  OP_MOV0 = 5'd10, OP_IMM  = 5'd11,
    OP_SHL  = 5'd12, OP_SHR  = 5'd13,
    OP_BNZ  = 5'd16, OP_BZ   = 5'd17, OP_B    = 5'd18, OP_BLZ  = 5'd19,
    OP_BGZ  = 5'd20,
    OP_LD   = 5'd24, OP_ST   = 5'd25, OP_CL   = 5'd26, OP_SWAP = 5'd27,
    OP_LDP  = 5'd28, OP_STP  = 5'd29
  } opcode_e;

  typedef enum logic [1:0] { DST_NONE, DST_ARG, DST_R0 } dst_e;

  typedef struct packed {
    dst_e dst;
    logic dmem_we;
    logic dmem_zero;
    logic pmem_we;
    logic is_branch;
    logic known;
  } ctl_t;

  // Register-side result for every data-processing opcode.
  function automatic word_t alu_result(opcode_e op, word_t rn, word_t r0, arg_t arg);
    word_t res;
    case (op)
      OP_AND:  res = rn & r0;
      OP_OR:   res = rn | r0;
      OP_NOT:  res = ~rn;
      OP_XOR:  res = rn ^ r0;
      OP_ADD:  res = rn + r0;
      OP_SUB:  res = rn - r0;
      OP_NEG:  res = word_t'(0) - rn;
      OP_MUL:  res = rn * r0;
      OP_DIV:  res = (r0 == '0) ? '1 : rn / r0;
      OP_MOV:  res = r0;
      OP_MOV0: res = rn;
      OP_IMM:  res = word_t'(arg);
      OP_SHL:  res = r0 << arg;
      OP_SHR:  res = r0 >> arg;
      default: res = '0;
    endcase
    return res;
  endfunction

  // Branch condition, evaluated on register zero.
  function automatic logic branch_cond(opcode_e op, word_t r0);
    logic neg, zero;
    neg  = r0[WORD_W-1];
    zero = (r0 == '0);
    case (op)
      OP_BNZ:  return !zero;
      OP_BZ:   return zero;
      OP_B:    return 1'b1;
      OP_BLZ:  return neg;
      OP_BGZ:  return !neg && !zero;
      default: return 1'b0;
    endcase
  endfunction

  function automatic ctl_t decode(opcode_e op);
    ctl_t c;
    c.dst       = DST_NONE;
    c.dmem_we   = 1'b0;
    c.dmem_zero = 1'b0;
    c.pmem_we   = 1'b0;
    c.is_branch = 1'b0;
    c.known     = 1'b1;
    case (op)
      OP_AND, OP_OR, OP_NOT, OP_XOR, OP_ADD, OP_SUB,
      OP_NEG, OP_MUL, OP_DIV, OP_MOV:             c.dst = DST_ARG;
      OP_MOV0, OP_IMM, OP_SHL, OP_SHR,
      OP_LD, OP_LDP:                              c.dst = DST_R0;
      OP_BNZ, OP_BZ, OP_B, OP_BLZ, OP_BGZ:        c.is_branch = 1'b1;
      OP_ST:   c.dmem_we = 1'b1;
      OP_CL:   begin c.dmem_we = 1'b1; c.dmem_zero = 1'b1; end
      OP_SWAP: begin c.dmem_we = 1'b1; c.dst = DST_R0; end
      OP_STP:  c.pmem_we = 1'b1;
      default: c.known = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/acc8_regs.sv
module acc8_regs #(
  parameter int W    = 8,
  parameter int NR   = 8,
  localparam int IW  = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b,
  output logic [W-1:0]  r0
);

  logic [W-1:0] regs [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign r0      = regs[0];

endmodule

// File: rtl/acc8_ram.sv
module acc8_ram #(
  parameter int AW  = 8,
  parameter int W   = 8,
  parameter int NRD = 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              load_en,
  input  logic              load_prog,
  input  logic [AW-1:0]     load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic [ARG_W-1:0]  peek_reg,
  output logic [WORD_W-1:0] peek_reg_data,
  input  logic [AW-1:0]     peek_addr,
  output logic [WORD_W-1:0] peek_dmem,
  output logic [WORD_W-1:0] peek_pmem,
  output logic [AW-1:0]     ip
);

  localparam int P_RD = 3;  // fetch, ld_p, peek
  localparam int D_RD = 2;  // ld/swap, peek

  // Named internal events (observed by the checker)
  logic          run;
  logic          br_taken;
  logic [AW-1:0] br_target;
  logic          core_reg_we;
  logic          core_dmem_we;
  logic          core_pmem_we;
  logic          ev_nop;

  word_t   instr, rn, r0, alu_out, reg_wdata;
  opcode_e op;
  arg_t    arg;
  ctl_t    ctl;
  arg_t    reg_waddr;
  logic [AW-1:0] mem_addr;

  logic [P_RD-1:0][AW-1:0]     p_raddr;
  logic [P_RD-1:0][WORD_W-1:0] p_rdata;
  logic [D_RD-1:0][AW-1:0]     d_raddr;
  logic [D_RD-1:0][WORD_W-1:0] d_rdata;

  logic          p_we, d_we;
  logic [AW-1:0] p_waddr, d_waddr;
  word_t         p_wdata, d_wdata;
  logic          side_wr;

  assign run   = !halt;
  assign instr = p_rdata[0];
  assign op    = opcode_e'(instr[WORD_W-1 -: OPC_W]);
  assign arg   = instr[ARG_W-1:0];
  assign ctl   = decode(op);

  acc8_regs #(.W(WORD_W), .NR(NREG)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (core_reg_we),
    .waddr   (reg_waddr),
    .wdata   (reg_wdata),
    .raddr_a (arg),
    .rdata_a (rn),
    .raddr_b (peek_reg),
    .rdata_b (peek_reg_data),
    .r0      (r0)
  );

  assign mem_addr  = rn[AW-1:0];
  assign alu_out   = alu_result(op, rn, r0, arg);
  assign br_taken  = run && ctl.is_branch && branch_cond(op, r0);
  assign br_target = mem_addr;
  assign ev_nop    = run && !ctl.known;

  always_comb begin
    case (op)
      OP_LD, OP_SWAP: reg_wdata = d_rdata[0];
      OP_LDP:         reg_wdata = p_rdata[1];
      default:        reg_wdata = alu_out;
    endcase
  end

  assign reg_waddr    = (ctl.dst == DST_R0) ? arg_t'(0) : arg;
  assign core_reg_we  = run && (ctl.dst != DST_NONE);
  assign core_dmem_we = run && ctl.dmem_we;
  assign core_pmem_we = run && ctl.pmem_we;

  // Side port may only write while the core is halted
  assign side_wr = halt && load_en;

  assign p_we    = core_pmem_we || (side_wr && load_prog);
  assign p_waddr = core_pmem_we ? mem_addr : load_addr;
  assign p_wdata = core_pmem_we ? r0 : load_data;

  assign d_we    = core_dmem_we || (side_wr && !load_prog);
  assign d_waddr = core_dmem_we ? mem_addr : load_addr;
  assign d_wdata = core_dmem_we ? (ctl.dmem_zero ? word_t'(0) : r0) : load_data;

  assign p_raddr[0] = ip;
  assign p_raddr[1] = mem_addr;
  assign p_raddr[2] = peek_addr;
  assign d_raddr[0] = mem_addr;
  assign d_raddr[1] = peek_addr;

  acc8_ram #(.AW(AW), .W(WORD_W), .NRD(P_RD)) u_pmem (
    .clk   (clk),
    .we    (p_we),
    .waddr (p_waddr),
    .wdata (p_wdata),
    .raddr (p_raddr),
    .rdata (p_rdata)
  );

  acc8_ram #(.AW(AW), .W(WORD_W), .NRD(D_RD)) u_dmem (
    .clk   (clk),
    .we    (d_we),
    .waddr (d_waddr),
    .wdata (d_wdata),
    .raddr (d_raddr),
    .rdata (d_rdata)
  );

  assign peek_pmem = p_rdata[2];
  assign peek_dmem = d_rdata[1];

  always_ff @(posedge clk) begin
    if (rst)           ip <= '0;
    else if (br_taken) ip <= br_target;
    else if (run)      ip <= ip + 1'b1;
  end

endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          halt,
  input logic [AW-1:0] ip,
  input logic          taken,
  input logic [AW-1:0] target,
  input logic          reg_we,
  input logic          dmem_we,
  input logic          pmem_we,
  input logic          nop
);

  // R1
  reset_ip_chk: assert property (@(posedge clk) rst |=> ip == '0);

  // R12
  step_ip_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && !taken) |=> ip == $past(ip) + 1'b1);

  // R6
  jump_ip_chk: assert property (@(posedge clk) disable iff (rst)
    (!halt && taken) |=> ip == $past(target));

  // R11
  hold_ip_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(ip));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halt |-> !(reg_we || dmem_we || pmem_we));

  // R10
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    nop |-> !(reg_we || dmem_we || pmem_we || taken));

  // R7
  one_mem_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dmem_we, pmem_we}));

endmodule

bind acc8_core acc8_core_chk #(.AW(AW)) u_acc8_core_chk (
  .clk     (clk),
  .rst     (rst),
  .halt    (halt),
  .ip      (ip),
  .taken   (br_taken),
  .target  (br_target),
  .reg_we  (core_reg_we),
  .dmem_we (core_dmem_we),
  .pmem_we (core_pmem_we),
  .nop     (ev_nop)
);

// File: tb/test_acc8_core.sv
module test_acc8_core;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  // opcode numbers, restated from the requirements
  localparam logic [4:0] C_AND = 0,  C_OR  = 1,  C_NOT = 2,  C_XOR = 3, C_ADD = 4,
                         C_SUB = 5,  C_NEG = 6,  C_MUL = 7,  C_DIV = 8, C_MOV = 9,
                         C_MOV0 = 10, C_IMM = 11, C_SHL = 12, C_SHR = 13,
                         C_BNZ = 16, C_BZ = 17, C_B = 18, C_BLZ = 19, C_BGZ = 20,
                         C_LD = 24, C_ST = 25, C_CL = 26, C_SWAP = 27, C_LDP = 28, C_STP = 29;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          halt = 1'b1;
  logic          load_en = 1'b0;
  logic          load_prog = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [7:0]    load_data = '0;
  logic [2:0]    peek_reg = '0;
  logic [7:0]    peek_reg_data;
  logic [AW-1:0] peek_addr = '0;
  logic [7:0]    peek_dmem, peek_pmem;
  logic [AW-1:0] ip;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc8_core #(.AW(AW)) i_acc8_core (
    .clk(clk), .rst(rst), .halt(halt),
    .load_en(load_en), .load_prog(load_prog), .load_addr(load_addr), .load_data(load_data),
    .peek_reg(peek_reg), .peek_reg_data(peek_reg_data),
    .peek_addr(peek_addr), .peek_dmem(peek_dmem), .peek_pmem(peek_pmem),
    .ip(ip)
  );

  function automatic logic [7:0] enc(input logic [4:0] op, input logic [2:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); halt = 1'b1; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic put(input logic prog, input int addr, input logic [7:0] data);
    @(negedge clk);
    load_en = 1'b1; load_prog = prog; load_addr = AW'(addr); load_data = data;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run(input int n);
    @(negedge clk); halt = 1'b0;
    repeat (n) @(negedge clk);
    halt = 1'b1;
  endtask

  task automatic reg_is(input string tag, input int idx, input logic [7:0] exp);
    peek_reg = 3'(idx); #1;
    chk(tag, peek_reg_data, exp);
  endtask

  task automatic dmem_is(input string tag, input int a, input logic [7:0] exp);
    peek_addr = AW'(a); #1;
    chk(tag, peek_dmem, exp);
  endtask

  task automatic pmem_is(input string tag, input int a, input logic [7:0] exp);
    peek_addr = AW'(a); #1;
    chk(tag, peek_pmem, exp);
  endtask

  task automatic ip_is(input string tag, input int exp);
    #1; chk(tag, 8'(ip), 8'(exp));
  endtask

  // R2 R3: two-operand and single-operand register work
  task automatic t_alu();
    do_reset();
    put(1, 0, enc(C_IMM, 5));
    put(1, 1, enc(C_MOV, 1)); put(1, 2, enc(C_MOV, 2));
    put(1, 3, enc(C_MOV, 3)); put(1, 4, enc(C_MOV, 4));
    put(1, 5, enc(C_IMM, 3));
    put(1, 6, enc(C_ADD, 1)); put(1, 7, enc(C_SUB, 2));
    put(1, 8, enc(C_XOR, 3)); put(1, 9, enc(C_MUL, 4));
    put(1, 10, enc(C_OR, 5)); put(1, 11, enc(C_NOT, 6));
    put(1, 12, enc(C_NEG, 5)); put(1, 13, enc(C_AND, 1));
    put(1, 14, enc(C_MOV0, 6)); put(1, 15, enc(C_MUL, 4));
    run(16);
    ip_is("R12 ip after 16 steps", 16);
    reg_is("R2 add then and (8&3)", 1, 8'h00);
    reg_is("R2 sub 5-3", 2, 8'h02);
    reg_is("R2 xor 5^3", 3, 8'h06);
    reg_is("R2 mul low byte 15*255", 4, 8'hF1);
    reg_is("R3 or then neg -3", 5, 8'hFD);
    reg_is("R3 not of zero", 6, 8'hFF);
    reg_is("R3 mov0 into r0", 0, 8'hFF);
  endtask

  // R1: reset clears state but keeps memory
  task automatic t_reset();
    do_reset();
    ip_is("R1 ip cleared", 0);
    for (int i = 0; i < 8; i++) reg_is("R1 register cleared", i, 8'h00);
    pmem_is("R1 program kept", 0, enc(C_IMM, 5));
  endtask

  // R4 R5 R3: shifts, divide, moves
  task automatic t_shift_div();
    do_reset();
    put(1, 0, enc(C_IMM, 7)); put(1, 1, enc(C_MOV, 1)); put(1, 2, enc(C_MOV, 3));
    put(1, 3, enc(C_IMM, 2)); put(1, 4, enc(C_DIV, 1));
    put(1, 5, enc(C_IMM, 0)); put(1, 6, enc(C_DIV, 3));
    put(1, 7, enc(C_IMM, 5)); put(1, 8, enc(C_SHL, 4)); put(1, 9, enc(C_SHR, 2));
    put(1, 10, enc(C_MOV, 2)); put(1, 11, enc(C_MOV0, 1)); put(1, 12, enc(C_MOV, 4));
    put(1, 13, enc(C_IMM, 6)); put(1, 14, enc(C_SHL, 5)); put(1, 15, enc(C_SHR, 7));
    run(16);
    ip_is("R12 ip after 16 steps", 16);
    reg_is("R5 7/2", 1, 8'h03);
    reg_is("R5 divide by zero", 3, 8'hFF);
    reg_is("R4 (5<<4)>>2", 2, 8'h14);
    reg_is("R3 mov0 then mov", 4, 8'h03);
    reg_is("R4 logical shr of 0xC0 by 7", 0, 8'h01);
  endtask

  // R6: taken and not-taken branches
  task automatic t_branch();
    do_reset();
    put(1, 0, enc(C_IMM, 7)); put(1, 1, enc(C_MOV, 1));
    put(1, 2, enc(C_IMM, 0)); put(1, 3, enc(C_BNZ, 1)); put(1, 4, enc(C_BZ, 1));
    put(1, 5, enc(C_IMM, 5)); put(1, 6, enc(C_IMM, 5));
    put(1, 7, enc(C_IMM, 1)); put(1, 8, enc(C_MOV, 2)); put(1, 9, enc(C_NEG, 2));
    put(1, 10, enc(C_IMM, 7)); put(1, 11, enc(C_MOV, 3));
    put(1, 12, enc(C_ADD, 3)); put(1, 13, enc(C_ADD, 3));
    put(1, 14, enc(C_MOV0, 2)); put(1, 15, enc(C_BGZ, 3)); put(1, 16, enc(C_BLZ, 3));
    for (int a = 17; a < 21; a++) put(1, a, enc(C_IMM, 5));
    put(1, 21, enc(C_IMM, 2)); put(1, 22, enc(C_BGZ, 6));
    run(5);
    ip_is("R6 bnz not taken, bz taken to 7", 7);
    run(12);
    ip_is("R6 bgz taken to r6=0", 0);
    reg_is("R6 skipped code not run", 0, 8'h02);
    reg_is("R3 neg of one", 2, 8'hFF);
    reg_is("R2 target sum", 3, 8'd21);
  endtask

  // R7 R8 R9: memory transfers
  task automatic t_memory();
    do_reset();
    put(0, 10, 8'hA5); put(0, 11, 8'h3C); put(0, 12, 8'h77); put(0, 14, 8'h99);
    put(1, 40, 8'h5A);
    put(1, 0, enc(C_IMM, 5)); put(1, 1, enc(C_MOV, 1)); put(1, 2, enc(C_ADD, 1));
    put(1, 3, enc(C_LD, 1)); put(1, 4, enc(C_MOV, 2));
    put(1, 5, enc(C_IMM, 7)); put(1, 6, enc(C_MOV, 3));
    put(1, 7, enc(C_IMM, 4)); put(1, 8, enc(C_ADD, 3));
    put(1, 9, enc(C_IMM, 2)); put(1, 10, enc(C_SWAP, 3)); put(1, 11, enc(C_MOV, 4));
    put(1, 12, enc(C_ST, 1));
    put(1, 13, enc(C_IMM, 4)); put(1, 14, enc(C_ADD, 1)); put(1, 15, enc(C_CL, 1));
    put(1, 16, enc(C_IMM, 5)); put(1, 17, enc(C_SHL, 3)); put(1, 18, enc(C_MOV, 5));
    put(1, 19, enc(C_LDP, 5)); put(1, 20, enc(C_MOV, 6));
    put(1, 21, enc(C_IMM, 7)); put(1, 22, enc(C_SHL, 3)); put(1, 23, enc(C_MOV, 7));
    put(1, 24, enc(C_IMM, 3)); put(1, 25, enc(C_STP, 7));
    run(26);
    ip_is("R12 ip after 26 steps", 26);
    reg_is("R7 ld from data word 10", 2, 8'hA5);
    reg_is("R8 swap read old word", 4, 8'h3C);
    dmem_is("R8 swap wrote old r0", 11, 8'h02);
    dmem_is("R7 st of r0", 10, 8'h3C);
    dmem_is("R7 cl wrote zero", 14, 8'h00);
    dmem_is("R7 other word untouched", 12, 8'h77);
    reg_is("R9 ld_p from program word 40", 6, 8'h5A);
    pmem_is("R9 st_p to program word 56", 56, 8'h03);
  endtask

  // R9 R10 R11: self-patching fetch, unassigned opcodes, halt and side port
  task automatic t_patch_halt();
    do_reset();
    put(0, 50, 8'h11);
    put(1, 0, enc(C_IMM, 4)); put(1, 1, enc(C_MOV, 1));
    put(1, 2, enc(C_IMM, 5)); put(1, 3, enc(C_SHL, 4)); put(1, 4, enc(C_MOV, 2));
    put(1, 5, enc(C_IMM, 1)); put(1, 6, enc(C_OR, 2));
    put(1, 7, enc(C_IMM, 6)); put(1, 8, enc(C_MOV, 3));
    put(1, 9, enc(C_IMM, 7)); put(1, 10, enc(C_ADD, 3));
    put(1, 11, enc(C_MOV0, 2)); put(1, 12, enc(C_STP, 3));
    put(1, 13, enc(C_IMM, 0));
    put(1, 14, 8'hF8); put(1, 15, 8'h72); put(1, 16, enc(C_B, 1));
    run(14);
    ip_is("R12 ip after 14 steps", 14);
    reg_is("R9 patched next word executed", 0, 8'h04);
    pmem_is("R9 patched word stored", 13, 8'h51);
    // run three more steps while the side port tries to write
    @(negedge clk);
    halt = 1'b0; load_en = 1'b1; load_prog = 1'b0; load_addr = AW'(50); load_data = 8'hEE;
    repeat (3) @(negedge clk);
    load_en = 1'b0; halt = 1'b1;
    ip_is("R6 b always to r1", 4);
    reg_is("R10 r0 untouched by unassigned opcodes", 0, 8'h04);
    reg_is("R10 r1 untouched", 1, 8'h04);
    reg_is("R10 r2 untouched", 2, 8'h51);
    reg_is("R10 r3 untouched", 3, 8'h0D);
    dmem_is("R11 side write ignored while running", 50, 8'h11);
    repeat (3) @(negedge clk);
    ip_is("R11 ip held while halted", 4);
    reg_is("R11 no register change while halted", 0, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_alu();
    t_reset();
    t_shift_div();
    t_branch();
    t_memory();
    t_patch_halt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule